// File: doc/BRIEF.md
# Machine Timer with Compare Interrupt

This block keeps a 64-bit machine time count and a 64-bit compare value, and raises a level-sensitive timer interrupt whenever the time has reached or passed the compare value. One count of the time value always stands for 10 ns, whatever rate the update strobe runs at. A tick-enable input carries the update strobe. The parameter `TICK_STEP` sets how many 10 ns units each strobe adds. A 100 MHz strobe uses a step of 1 and a 10 MHz strobe uses a step of 10, so every allowed rate keeps the count strictly increasing.

Software reaches both values through a 32-bit register port with a 2-bit word address. It arms an interrupt by writing the compare value as the current time plus the wanted delay in 10 ns units. For example, 1 ms later is the current time plus 100,000. Reads are registered. A read of the low time word also captures the high time word, so a following read of the high word returns a value that matches that low word.

Top module: `mtimer`

## Requirements
- R1: After reset the time value is 0, the compare value is all ones, `timerIrq` is low and `rdData` is 0.
- R2: In each cycle with `tickEn` high and no write to a time word, the time value grows by `TICK_STEP`, carrying from the low word into the high word. With `tickEn` low and no time write, the time value holds.
- R3: A write to address 0 (time bits 31:0) or address 1 (time bits 63:32) replaces that half on the next clock edge. In that cycle the written value takes the place of any tick.
- R4: A write to address 2 (compare bits 31:0) or address 3 (compare bits 63:32) replaces that half of the compare value on the next clock edge.
- R5: `timerIrq` is high exactly when the time value is greater than or equal to the compare value, compared as unsigned 64-bit numbers. It drops once the compare value is rewritten above the time value.
- R6: A read with `rdEn` high places the addressed word on `rdData` at the next clock edge. Addresses 2 and 3 return the compare halves. Otherwise `rdData` holds.
- R7: A read of address 0 returns time bits 31:0 and captures time bits 63:32 at the same edge. A read of address 1 returns that captured word, even if the time has moved on since.
- R8: The time value wraps from all ones to zero modulo 2^64 and raises no other indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Time update strobe, one step per high cycle |
| wrEn | input | 1 | Register write request |
| rdEn | input | 1 | Register read request |
| addr | input | 2 | Word address: 0/1 time low/high, 2/3 compare low/high |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| timerIrq | output | 1 | Timer interrupt, level |

## Verification
The bench builds the timer with `TICK_STEP` set to 10, which models the slowest allowed 10 MHz strobe. At that step a few ticks carry the low word across its 32-bit boundary into the high word, and the count wraps at its 64-bit end. The compare equality edge can be reached exactly in whole-step ticks. A step larger than 1 also shows a tick-plus-write cycle, because an added step and the written value then differ visibly.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  localparam int HALF_W = 32;
  localparam int TIME_W = 2 * HALF_W;

  typedef enum logic [1:0] {
    REG_TIME_LO = 2'd0,
    REG_TIME_HI = 2'd1,
    REG_CMP_LO  = 2'd2,
    REG_CMP_HI  = 2'd3
  } mtReg_t;

  typedef struct packed {
    logic tick;
    logic wrTimeLo;
    logic wrTimeHi;
    logic wrCmpLo;
    logic wrCmpHi;
    logic rdTimeLo;
    logic rdTimeHi;
    logic rdCmpLo;
    logic rdCmpHi;
  } mtStrobe_t;
endpackage

// File: rtl/mtimer_ctrl.sv
module mtimer_ctrl
  import mtimer_pkg::*;
(
  input  logic       tickEn,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] addr,
  output mtStrobe_t  strobe
);
  mtReg_t regSel;

  always_comb begin
    regSel          = mtReg_t'(addr);
    strobe          = '0;
    strobe.tick     = tickEn;
    strobe.wrTimeLo = wrEn && (regSel == REG_TIME_LO);
    strobe.wrTimeHi = wrEn && (regSel == REG_TIME_HI);
    strobe.wrCmpLo  = wrEn && (regSel == REG_CMP_LO);
    strobe.wrCmpHi  = wrEn && (regSel == REG_CMP_HI);
    strobe.rdTimeLo = rdEn && (regSel == REG_TIME_LO);
    strobe.rdTimeHi = rdEn && (regSel == REG_TIME_HI);
    strobe.rdCmpLo  = rdEn && (regSel == REG_CMP_LO);
    strobe.rdCmpHi  = rdEn && (regSel == REG_CMP_HI);
  end
endmodule

// File: rtl/mtimer_dp.sv
module mtimer_dp
  import mtimer_pkg::*;
#(
  parameter int TICK_STEP = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  mtStrobe_t         strobe,
  input  logic [HALF_W-1:0] wrData,
  output logic [HALF_W-1:0] rdData,
  output logic              timerIrq
);
  localparam logic [TIME_W-1:0] STEP = TIME_W'(TICK_STEP);

  logic [TIME_W-1:0] timeVal;
  logic [TIME_W-1:0] cmpVal;
  logic [HALF_W-1:0] snapHi;
  logic [1:0]        cmpWr;

  // Time counter: a software write wins over the step in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeVal <= '0;
    end else if (strobe.wrTimeLo) begin
      timeVal <= {timeVal[TIME_W-1:HALF_W], wrData};
    end else if (strobe.wrTimeHi) begin
      timeVal <= {wrData, timeVal[HALF_W-1:0]};
    end else if (strobe.tick) begin
      timeVal <= timeVal + STEP;
    end
  end

  // Compare register, one generated slice per 32-bit half.
  assign cmpWr = {strobe.wrCmpHi, strobe.wrCmpLo};
  for (genvar h = 0; h < 2; h++) begin : g_cmpHalf
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpVal[h*HALF_W +: HALF_W] <= '1;
      end else if (cmpWr[h]) begin
        cmpVal[h*HALF_W +: HALF_W] <= wrData;
      end
    end
  end

  // Registered read path with a high-word snapshot taken on low reads.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
      snapHi <= '0;
    end else begin
      if (strobe.rdTimeLo) begin
        rdData <= timeVal[HALF_W-1:0];
        snapHi <= timeVal[TIME_W-1:HALF_W];
      end else if (strobe.rdTimeHi) begin
        rdData <= snapHi;
      end else if (strobe.rdCmpLo) begin
        rdData <= cmpVal[HALF_W-1:0];
      end else if (strobe.rdCmpHi) begin
        rdData <= cmpVal[TIME_W-1:HALF_W];
      end
    end
  end

  assign timerIrq = (timeVal >= cmpVal);

  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !strobe.wrTimeLo && !strobe.wrTimeHi)
      |=> (timeVal == $past(timeVal) + STEP));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.wrTimeLo && !strobe.wrTimeHi)
      |=> $stable(timeVal));

  p_wr_lo_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrTimeLo |=> (timeVal[HALF_W-1:0] == $past(wrData)));

  p_cmp_lo_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrCmpLo |=> (cmpVal[HALF_W-1:0] == $past(wrData)));

  p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerIrq) |-> (!$stable(timeVal) || !$stable(cmpVal)));

  p_snap_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdTimeLo |=> (snapHi == $past(timeVal[TIME_W-1:HALF_W])));
endmodule

// File: rtl/mtimer.sv
module mtimer
  import mtimer_pkg::*;
#(
  parameter int TICK_STEP = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [1:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        timerIrq
);
  mtStrobe_t strobe;

  mtimer_ctrl u_ctrl (
    .tickEn (tickEn),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .strobe (strobe)
  );

  mtimer_dp #(.TICK_STEP(TICK_STEP)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .rdData   (rdData),
    .timerIrq (timerIrq)
  );
endmodule

// File: tb/mtimer_test.sv
module mtimer_test;
  localparam int STEP = 10;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TICK = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  addr;
    logic [31:0] data;
    logic [31:0] expVal;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{OP_RD,   2'd0, 32'h0,        32'h0,        4'd1},
    '{OP_RD,   2'd1, 32'h0,        32'h0,        4'd1},
    '{OP_RD,   2'd2, 32'h0,        32'hFFFFFFFF, 4'd1},
    '{OP_RD,   2'd3, 32'h0,        32'hFFFFFFFF, 4'd1},
    '{OP_TICK, 2'd0, 32'd5,        32'h0,        4'd2},
    '{OP_RD,   2'd0, 32'h0,        32'd50,       4'd2},
    '{OP_WR,   2'd2, 32'h1234,     32'h0,        4'd4},
    '{OP_WR,   2'd3, 32'hABCD,     32'h0,        4'd4},
    '{OP_RD,   2'd2, 32'h0,        32'h1234,     4'd4},
    '{OP_RD,   2'd3, 32'h0,        32'hABCD,     4'd4},
    '{OP_WR,   2'd0, 32'hFFFFFFF0, 32'h0,        4'd3},
    '{OP_WR,   2'd1, 32'd5,        32'h0,        4'd3},
    '{OP_TICK, 2'd0, 32'd2,        32'h0,        4'd2},
    '{OP_RD,   2'd0, 32'h0,        32'd4,        4'd2},
    '{OP_RD,   2'd1, 32'h0,        32'd6,        4'd7}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        timerIrq;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  mtimer #(.TICK_STEP(STEP)) uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .timerIrq(timerIrq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input string tag, input logic [31:0] exp);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    check(tag, rdData, exp);
  endtask

  task automatic ticks(input int n);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state on the outputs
    check("R1 rdData after reset", rdData, 32'h0);
    check("R1 irq after reset", {31'b0, timerIrq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      case (VECS[i].op)
        OP_WR:   wr(VECS[i].addr, VECS[i].data);
        OP_TICK: ticks(int'(VECS[i].data));
        default: rd(VECS[i].addr, $sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].expVal);
      endcase
    end

    // R5: compare edge at equality, level, cleared by rewrite
    wr(2'd1, 32'd0); wr(2'd0, 32'd0);
    wr(2'd2, 32'd100); wr(2'd3, 32'd0);
    check("R5 irq low below compare", {31'b0, timerIrq}, 32'h0);
    ticks(9);
    check("R5 irq low at 90", {31'b0, timerIrq}, 32'h0);
    ticks(1);
    check("R5 irq high at equality", {31'b0, timerIrq}, 32'h1);
    ticks(1);
    check("R5 irq stays high past compare", {31'b0, timerIrq}, 32'h1);
    wr(2'd2, 32'd200);
    check("R5 irq clears on compare rewrite", {31'b0, timerIrq}, 32'h0);

    // R2: no tick holds the time
    rd(2'd0, "R2 time before idle", 32'd110);
    repeat (4) @(negedge clk);
    rd(2'd0, "R2 time holds without tick", 32'd110);

    // R3: write in a tick cycle replaces the step
    tickEn = 1'b1;
    wr(2'd0, 32'd7);
    tickEn = 1'b0;
    rd(2'd0, "R3 write overrides tick", 32'd7);

    // R7: high word read returns the snapshot from the low read
    wr(2'd1, 32'd3); wr(2'd0, 32'hFFFFFFFB);
    rd(2'd0, "R7 low word", 32'hFFFFFFFB);
    ticks(1);
    rd(2'd1, "R7 snapshot high after carry", 32'd3);
    rd(2'd0, "R7 low after carry", 32'd5);
    rd(2'd1, "R7 fresh high after new low read", 32'd4);

    // R8: wrap modulo 2^64 with compare all ones
    wr(2'd2, 32'hFFFFFFFF); wr(2'd3, 32'hFFFFFFFF);
    wr(2'd1, 32'hFFFFFFFF); wr(2'd0, 32'hFFFFFFFB);
    check("R8 irq low just below all ones", {31'b0, timerIrq}, 32'h0);
    ticks(1);
    rd(2'd0, "R8 low after wrap", 32'd5);
    rd(2'd1, "R8 high after wrap", 32'd0);
    check("R8 irq low after wrap", {31'b0, timerIrq}, 32'h0);

    // R6: rdData holds when no read is issued
    repeat (3) @(negedge clk);
    check("R6 rdData holds without read", rdData, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule